// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block contains two periodic timers that run on the system clock and work independently of each other. Each timer has two 16-bit reload values, a prescale value and a divide value, which a host writes over a small 16-bit register bus. The prescale stage counts system clocks down to zero and then reloads. Each time it wraps, it steps the divide stage down by one. When both stages are at zero, the timer raises a single-cycle request on its `irq` bit, reloads both stages and keeps running without further programming.

Both live count stages of both timers can be read back at any time through a combinational read port. Writing a full word to any reload register of a timer restarts that timer at once from the programmed values. If both reload values of a timer are zero, the timer stops. Interrupt masking, priority and bus arbitration are left to the logic around this block.

Top module: `dual_interval_timer`

## Requirements
- R1: Full 16-bit writes set the reload values at these offsets: 0x00 (timer 0 prescale), 0x02 (timer 0 divide), 0x04 (timer 1 prescale) and 0x06 (timer 1 divide). The interval between expiry pulses is (prescale + 1) × (divide + 1) clock cycles.
- R2: Each expiry asserts the timer's `irq` bit (bit 0 for timer 0, bit 1 for timer 1) high for exactly one clock cycle.
- R3: After an expiry the timer reloads both stages and expires again one full interval later, with no host action.
- R4: A full write to either reload register of a timer discards its current count. The first expiry then comes one full interval, computed from the new values, after the write edge.
- R5: A timer whose prescale and divide reload values are both zero produces no expiry, and both of its count stages read zero.
- R6: While reset is asserted, all four reload values and all four count stages are 0xFFFF and `irq` is zero. Counting begins on the first edge after reset is released.
- R7: Reads return the live count stages at these offsets: 0x36 (timer 0 prescale), 0x38 (timer 0 divide), 0x3A (timer 1 prescale) and 0x3C (timer 1 divide). Any other offset reads zero.
- R8: A write whose byte enables `bus_be` are not both set (2'b11) changes no reload value and does not restart the timer.
- R9: Programming one timer never changes the count or the expiry phase of the other timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_be | input | 2 | Byte enables; only 2'b11 performs a write |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irq | output | 2 | Single-cycle expiry pulse per timer |

## Verification
The bench builds the block with its default parameters: two timers, 16-bit stages, an 8-bit offset and a reset value of 0xFFFF. Because the reset value makes the first interval about four billion cycles, every timing check first programs small reload values. That puts intervals of 2 to 25 cycles within reach, and with them exact cycle counts for the first and the repeated expiry. The reset value is checked only through the count read-back and the first decrement. Short intervals also make it practical to restart a timer part way through an interval, and to program the second timer while the first is counting.

// File: rtl/pit_pkg.sv
package pit_pkg;

    parameter int unsigned CNT_W       = 16;
    parameter int unsigned ADDR_W      = 8;
    parameter int unsigned N_TMR       = 2;
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFF;

    localparam int unsigned SLOT_STRIDE = 4;
    localparam int unsigned TMR_IDX_W   = (N_TMR > 1) ? $clog2(N_TMR) : 1;
    localparam logic [ADDR_W-1:0] WR_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] RD_BASE = 8'h36;
    localparam logic [1:0] BE_FULL = 2'b11;

    // Reload values or live count of one timer
    typedef struct packed {
        logic [CNT_W-1:0] presc;
        logic [CNT_W-1:0] div;
    } stage_pair_t;

    // Result of decoding a bus offset inside a slot window
    typedef struct packed {
        logic                 hit;
        logic [TMR_IDX_W-1:0] tmr;
        logic                 is_div;
    } slot_sel_t;

    function automatic slot_sel_t decode_slot(input logic [ADDR_W-1:0] addr,
                                              input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] off;
        slot_sel_t         s;
        off      = addr - base;
        s.hit    = (addr >= base) && (off < ADDR_W'(N_TMR * SLOT_STRIDE)) && (off[0] == 1'b0);
        s.tmr    = off[TMR_IDX_W+1:2];
        s.is_div = off[1];
        return s;
    endfunction

    function automatic stage_pair_t reset_pair();
        stage_pair_t p;
        p.presc = RST_VAL;
        p.div   = RST_VAL;
        return p;
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [CNT_W-1:0]               bus_wdata,
    input  logic                           bus_we,
    input  logic [1:0]                     bus_be,
    output stage_pair_t [N_TMR-1:0]        rel_q,
    output stage_pair_t [N_TMR-1:0]        rel_nxt,
    output logic [N_TMR-1:0]               load
);

    slot_sel_t wsel;
    logic      wr_full;

    assign wsel    = decode_slot(bus_addr, WR_BASE);
    assign wr_full = bus_we && (bus_be == BE_FULL) && wsel.hit;

    for (genvar i = 0; i < N_TMR; i++) begin : g_slot
        logic mine;
        assign mine = wr_full && (wsel.tmr == TMR_IDX_W'(i));

        always_comb begin
            rel_nxt[i] = rel_q[i];
            load[i]    = 1'b0;
            if (mine) begin
                load[i] = 1'b1;
                if (wsel.is_div) rel_nxt[i].div   = bus_wdata;
                else             rel_nxt[i].presc = bus_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) rel_q[i] <= reset_pair();
            else     rel_q[i] <= rel_nxt[i];
        end

        // R8: partial-width writes leave the reload values untouched
        p_partial_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_be != BE_FULL) |=> $stable(rel_q[i]));
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stage_pair_t rel,
    input  stage_pair_t rel_nxt,
    input  logic        load,
    output stage_pair_t cnt,
    output logic        fire
);

    logic running;
    logic at_end;

    assign running = (rel.presc != '0) || (rel.div != '0);
    assign at_end  = (cnt.presc == '0) && (cnt.div == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= reset_pair();
            fire <= 1'b0;
        end else if (load) begin
            cnt  <= rel_nxt;
            fire <= 1'b0;
        end else if (running) begin
            fire <= at_end;
            if (cnt.presc == '0) begin
                cnt.presc <= rel.presc;
                if (cnt.div == '0) cnt.div <= rel.div;
                else               cnt.div <= cnt.div - 1'b1;
            end else begin
                cnt.presc <= cnt.presc - 1'b1;
            end
        end else begin
            fire <= 1'b0;
        end
    end

    // R1: the prescale stage steps down by one while counting
    p_presc_step_r1: assert property (@(posedge clk) disable iff (rst)
        (running && !load && cnt.presc != '0) |=> (cnt.presc == $past(cnt.presc) - 1'b1));

    // R1: an expiry only follows a cycle in which both stages were zero
    p_fire_at_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(fire) |-> ($past(cnt.presc) == '0 && $past(cnt.div) == '0));

    // R2: expiry lasts a single cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R4: a write restarts the count from the new reload values
    p_restart_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(rel_nxt)) && !fire);

    // R5: a stopped timer stays silent
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> !fire);

endmodule

// File: rtl/pit_readmux.sv
module pit_readmux
    import pit_pkg::*;
(
    input  logic [ADDR_W-1:0]       bus_addr,
    input  stage_pair_t [N_TMR-1:0] cnt,
    output logic [CNT_W-1:0]        bus_rdata
);

    slot_sel_t rsel;
    assign rsel = decode_slot(bus_addr, RD_BASE);

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (rsel.hit && rsel.tmr == TMR_IDX_W'(i)) begin
                bus_rdata = rsel.is_div ? cnt[i].div : cnt[i].presc;
            end
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic [1:0]        bus_be,
    output logic [15:0]       bus_rdata,
    output logic [1:0]        irq
);

    stage_pair_t [N_TMR-1:0] rel_q;
    stage_pair_t [N_TMR-1:0] rel_nxt;
    stage_pair_t [N_TMR-1:0] cnt;
    logic [N_TMR-1:0]        load;

    pit_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_be   (bus_be),
        .rel_q    (rel_q),
        .rel_nxt  (rel_nxt),
        .load     (load)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        pit_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .rel    (rel_q[i]),
            .rel_nxt(rel_nxt[i]),
            .load   (load[i]),
            .cnt    (cnt[i]),
            .fire   (irq[i])
        );
    end

    pit_readmux u_rd (
        .bus_addr (bus_addr),
        .cnt      (cnt),
        .bus_rdata(bus_rdata)
    );

    // R6: no request leaves the block in the cycle after reset
    p_reset_quiet_r6: assert property (@(posedge clk)
        rst |=> (irq == '0));

endmodule

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_interval_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {timer, prescale, divide}
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'd1, 16'd0},
        {1'b1, 16'd0, 16'd1},
        {1'b0, 16'd2, 16'd3},
        {1'b1, 16'd4, 16'd4},
        {1'b0, 16'd0, 16'd5},
        {1'b1, 16'd7, 16'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_be    = 2'b11;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // Cycles from now until irq[t] is seen, capped
    task automatic wait_fire(input int t, input int cap, output int c);
        c = 0;
        while (c < cap) begin
            @(negedge clk);
            c++;
            if (irq[t]) break;
        end
    endtask

    initial begin
        int v;
        int c;
        int n;
        int seen;
        // R6: reset state
        @(negedge clk);
        @(negedge clk);
        rd(8'h36, v); chk("R6", v, 16'hFFFF);
        rd(8'h38, v); chk("R6", v, 16'hFFFF);
        rd(8'h3A, v); chk("R6", v, 16'hFFFF);
        rd(8'h3C, v); chk("R6", v, 16'hFFFF);
        chk("R6", int'(irq), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'h36, v); chk("R6", v, 16'hFFFE);

        // R1/R2/R3: vector table
        for (int k = 0; k < NV; k++) begin
            int t;
            int p;
            int d;
            t = int'(VEC[k][32]);
            p = int'(VEC[k][31:16]);
            d = int'(VEC[k][15:0]);
            n = (p + 1) * (d + 1);
            @(negedge clk);
            wr(8'(t * 4 + 2), 16'(d), 2'b11);
            wr(8'(t * 4), 16'(p), 2'b11);
            wait_fire(t, 2000, c);
            chk("R1", c, n);
            @(negedge clk);
            chk("R2", int'(irq[t]), 0);
            wait_fire(t, 2000, c);
            chk("R3", c + 1, n);
        end

        // R7: live count read-back
        @(negedge clk);
        wr(8'h06, 16'd2, 2'b11);
        wr(8'h04, 16'd3, 2'b11);
        rd(8'h3A, v); chk("R7", v, 3);
        rd(8'h3C, v); chk("R7", v, 2);
        @(negedge clk);
        rd(8'h3A, v); chk("R7", v, 2);
        rd(8'h10, v); chk("R7", v, 0);

        // R4: restart part way through an interval
        @(negedge clk);
        wr(8'h02, 16'd0, 2'b11);
        wr(8'h00, 16'd9, 2'b11);
        repeat (6) @(negedge clk);
        wr(8'h00, 16'd9, 2'b11);
        wait_fire(0, 200, c);
        chk("R4", c, 10);

        // R9: program timer 1 while timer 0 counts
        @(negedge clk);
        wr(8'h00, 16'd9, 2'b11);
        repeat (3) @(negedge clk);
        wr(8'h04, 16'd1, 2'b11);
        wait_fire(0, 200, c);
        chk("R9", c + 4, 10);

        // R5: both reload values zero stops the timer
        wr(8'h00, 16'd0, 2'b11);
        wr(8'h02, 16'd0, 2'b11);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq[0]) seen++;
        end
        chk("R5", seen, 0);
        rd(8'h36, v); chk("R5", v, 0);
        rd(8'h38, v); chk("R5", v, 0);

        // R8: partial writes ignored
        @(negedge clk);
        wr(8'h00, 16'd5, 2'b01);
        wr(8'h02, 16'd5, 2'b10);
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (irq[0]) seen++;
        end
        chk("R8", seen, 0);
        rd(8'h36, v); chk("R8", v, 0);
        rd(8'h38, v); chk("R8", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule